// File: doc/BRIEF.md
# Replay Input Event Logger

This block captures the inputs that a deterministic replayer cannot rebuild from memory-race records alone. It watches three paths. The trap path carries asynchronous interrupts, tagged with the running committed-instruction count of the processor. The programmed-I/O path carries device reads, whose returned values must be reproduced. The DMA path carries incoming data beats. Each event becomes a tagged record in one shared output stream. The stream is held in a small FIFO until a downstream consumer takes it.

DMA is treated as a pseudo-processor with its own beat count. Every accepted DMA beat advances that count by one. When a beat conflicts with an earlier processor access, the logger also emits an ordering arc. The arc's start is the processor's instruction count, and its end is the DMA beat count. Synchronous exceptions are left out of the log, because replay regenerates them. Programmed-I/O stores are left out for the same reason.

Up to four records can arise in one cycle. The logger writes one record per cycle into the FIFO and parks the rest in a staging register. While records are parked, or while the FIFO is full, it raises a stall signal, and sources hold back new events.

Top module: `replay_io_logger`

## Requirements
- R1: After synchronous reset, `stall` and `rec_valid` are 0. The DMA beat count is cleared, so the first accepted beat carries count 1.
- R2: An accepted cycle with `trap_valid`=1 and `trap_async`=1 produces a record with kind 0, count equal to `icount` in that cycle, and data equal to `trap_type` zero-extended.
- R3: A trap with `trap_async`=0, which is a synchronous exception, produces no record.
- R4: An accepted cycle with `io_valid`=1 and `io_is_load`=1 produces a record with kind 1, count equal to `icount`, and data equal to `io_data`.
- R5: An I/O access with `io_is_load`=0, which is a store, produces no record.
- R6: An accepted DMA beat produces a record with kind 2, data equal to `dma_data`, and count equal to the number of DMA beats accepted since reset, this beat included.
- R7: An accepted DMA beat with `dma_conflict`=1 also produces a record with kind 3. Its count is the same beat count as in R6, and its data is `dma_conflict_ic` zero-extended.
- R8: Records born in the same cycle enter the stream in kind order: 0, then 1, then 2, then 3.
- R9: `stall` is 1 exactly when staged records remain or the FIFO holds DEPTH records. Events presented while `stall`=1 are ignored: they produce no record and do not advance the DMA count.
- R10: Records leave in the order they were written. `rec_valid` is 1 whenever the FIFO is non-empty. A record is removed on a clock edge where both `rec_valid` and `rec_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icount | input | ICW | Committed-instruction count of the processor |
| trap_valid | input | 1 | Trap taken this cycle |
| trap_async | input | 1 | 1 = interrupt, 0 = synchronous exception |
| trap_type | input | TW | Interrupt type |
| io_valid | input | 1 | Programmed-I/O access completes |
| io_is_load | input | 1 | 1 = load, 0 = store |
| io_data | input | DW | Value returned by the I/O load |
| dma_valid | input | 1 | DMA input beat |
| dma_data | input | DW | DMA beat data |
| dma_conflict | input | 1 | Beat conflicts with an earlier processor access |
| dma_conflict_ic | input | ICW | Instruction count of the conflicting processor access |
| stall | output | 1 | Sources must hold new events |
| rec_valid | output | 1 | A record is available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_kind | output | 2 | Record kind: 0 interrupt, 1 I/O load, 2 DMA data, 3 DMA arc |
| rec_count | output | ICW | Instruction count or DMA beat count |
| rec_data | output | DW | Record payload |

## Verification
The collision that matters is an interrupt, an I/O load and a conflicting DMA beat all arriving in one cycle. This creates four records that must be serialized over four cycles while `stall` holds the sources off. The bench provokes this once on purpose. It then provokes it repeatedly by random stimulus, including while the consumer stalls the FIFO into fullness. A reference model in the bench tracks the staged count, the FIFO occupancy and the DMA beat count. It judges each cycle's `stall`, and it checks every record against the expected kind-ordered queue.

// File: rtl/rlog_pkg.sv
package rlog_pkg;
  typedef enum logic [1:0] {
    K_IRQ  = 2'd0,
    K_IOLD = 2'd1,
    K_DMA  = 2'd2,
    K_ARC  = 2'd3
  } rec_kind_e;

  localparam int NUM_SRC = 4;
  localparam int KIND_W  = 2;
endpackage

// File: rtl/rlog_dma_seq.sv
module rlog_dma_seq #(
  parameter int ICW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           beat_acc,
  output logic [ICW-1:0] beat_cnt
);
  logic [ICW-1:0] seq_q;

  always_ff @(posedge clk) begin
    if (rst) seq_q <= '0;
    else if (beat_acc) seq_q <= seq_q + 1'b1;
  end

  // count carried by the beat presented this cycle
  assign beat_cnt = seq_q + 1'b1;

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !beat_acc |=> $stable(seq_q)); // R9
endmodule

// File: rtl/rlog_fifo.sv
module rlog_fifo #(
  parameter int W     = 50,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         valid,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  assign full  = (cnt_q == CW'(DEPTH));
  assign valid = (cnt_q != '0);
  assign push  = wr_en && !full;
  assign pop   = rd_en && valid;

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign rd_data = mem[rp_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)); // R10
endmodule

// File: rtl/rlog_capture.sv
module rlog_capture #(
  parameter int ICW  = 16,
  parameter int DW   = 32,
  parameter int NSRC = rlog_pkg::NUM_SRC
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      accept,
  input  logic                      full,
  input  logic [NSRC-1:0]           in_vld,
  input  logic [NSRC-1:0][ICW-1:0]  in_cnt,
  input  logic [NSRC-1:0][DW-1:0]   in_dat,
  output logic                      wr_en,
  output logic [$clog2(NSRC)-1:0]   wr_kind,
  output logic [ICW-1:0]            wr_cnt,
  output logic [DW-1:0]             wr_dat,
  output logic                      pend_any
);
  localparam int SW = $clog2(NSRC);

  logic [NSRC-1:0]          pend_q, pend_d, cand, grant;
  logic [NSRC-1:0][ICW-1:0] pcnt_q;
  logic [NSRC-1:0][DW-1:0]  pdat_q;
  logic [SW-1:0]            sel;

  always_comb begin
    cand = accept ? in_vld : (full ? '0 : pend_q);
    sel  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) sel = SW'(i);
    end
    grant   = (cand == '0) ? '0 : (NSRC'(1) << sel);
    wr_en   = |cand;
    wr_kind = sel;
    wr_cnt  = accept ? in_cnt[sel] : pcnt_q[sel];
    wr_dat  = accept ? in_dat[sel] : pdat_q[sel];
    pend_d  = (accept ? in_vld : pend_q) & ~grant;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pcnt_q <= in_cnt;
      pdat_q <= in_dat;
    end
  end

  assign pend_any = |pend_q;

  AST_DRAIN_ONE: assert property (@(posedge clk) disable iff (rst)
    (!accept && !full && pend_any) |=>
      ($countones(pend_q) == $past($countones(pend_q)) - 1)); // R8
  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
    (!accept && full) |=> $stable(pend_q)); // R9
endmodule

// File: rtl/replay_io_logger.sv
module replay_io_logger #(
  parameter int ICW   = 16,
  parameter int DW    = 32,
  parameter int TW    = 4,
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [ICW-1:0] icount,
  input  logic           trap_valid,
  input  logic           trap_async,
  input  logic [TW-1:0]  trap_type,
  input  logic           io_valid,
  input  logic           io_is_load,
  input  logic [DW-1:0]  io_data,
  input  logic           dma_valid,
  input  logic [DW-1:0]  dma_data,
  input  logic           dma_conflict,
  input  logic [ICW-1:0] dma_conflict_ic,
  output logic           stall,
  output logic           rec_valid,
  input  logic           rec_ready,
  output logic [1:0]     rec_kind,
  output logic [ICW-1:0] rec_count,
  output logic [DW-1:0]  rec_data
);
  import rlog_pkg::*;

  localparam int RW = KIND_W + ICW + DW;

  logic                         accept, pend_any, fifo_full, wr_en;
  logic [NUM_SRC-1:0]           in_vld;
  logic [NUM_SRC-1:0][ICW-1:0]  in_cnt;
  logic [NUM_SRC-1:0][DW-1:0]   in_dat;
  logic [ICW-1:0]               beat_cnt, wr_cnt;
  logic [DW-1:0]                wr_dat;
  logic [KIND_W-1:0]            wr_kind;
  logic [RW-1:0]                rd_rec;

  assign stall  = pend_any || fifo_full;
  assign accept = !stall;

  always_comb begin
    in_vld[K_IRQ]  = trap_valid && trap_async;
    in_vld[K_IOLD] = io_valid && io_is_load;
    in_vld[K_DMA]  = dma_valid;
    in_vld[K_ARC]  = dma_valid && dma_conflict;
    in_cnt[K_IRQ]  = icount;
    in_cnt[K_IOLD] = icount;
    in_cnt[K_DMA]  = beat_cnt;
    in_cnt[K_ARC]  = beat_cnt;
    in_dat[K_IRQ]  = DW'(trap_type);
    in_dat[K_IOLD] = io_data;
    in_dat[K_DMA]  = dma_data;
    in_dat[K_ARC]  = DW'(dma_conflict_ic);
  end

  rlog_dma_seq #(.ICW(ICW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .beat_acc (accept && dma_valid),
    .beat_cnt (beat_cnt)
  );

  rlog_capture #(.ICW(ICW), .DW(DW), .NSRC(NUM_SRC)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .full     (fifo_full),
    .in_vld   (in_vld),
    .in_cnt   (in_cnt),
    .in_dat   (in_dat),
    .wr_en    (wr_en),
    .wr_kind  (wr_kind),
    .wr_cnt   (wr_cnt),
    .wr_dat   (wr_dat),
    .pend_any (pend_any)
  );

  rlog_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data ({wr_kind, wr_cnt, wr_dat}),
    .rd_en   (rec_ready),
    .rd_data (rd_rec),
    .valid   (rec_valid),
    .full    (fifo_full)
  );

  assign {rec_kind, rec_count, rec_data} = rd_rec;

  AST_EXC_SILENT: assert property (@(posedge clk) disable iff (rst)
    (accept && trap_valid && !trap_async && !io_valid && !dma_valid) |-> !wr_en); // R3
  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (accept && io_valid && !io_is_load && !trap_valid && !dma_valid) |-> !wr_en); // R5
  AST_EVENT_WRITES: assert property (@(posedge clk) disable iff (rst)
    (accept && (in_vld != '0)) |-> wr_en); // R2
endmodule

// File: tb/test_replay_io_logger.sv
module test_replay_io_logger;
  localparam int ICW = 16, DW = 32, TW = 4, DEPTH = 8;
  localparam int RW = 2 + ICW + DW;

  logic clk = 0, rst = 1;
  logic [ICW-1:0] icount = '0;
  logic trap_valid = 0, trap_async = 0, io_valid = 0, io_is_load = 0;
  logic dma_valid = 0, dma_conflict = 0, rec_ready = 0;
  logic [TW-1:0] trap_type = '0;
  logic [DW-1:0] io_data = '0, dma_data = '0;
  logic [ICW-1:0] dma_conflict_ic = '0;
  logic stall, rec_valid;
  logic [1:0] rec_kind;
  logic [ICW-1:0] rec_count;
  logic [DW-1:0] rec_data;

  // staged stimulus, applied at the next falling edge
  logic n_tv, n_ta, n_iv, n_il, n_dv, n_dc, n_rdy;
  logic [TW-1:0] n_tt;
  logic [DW-1:0] n_id, n_dd;
  logic [ICW-1:0] n_ic, n_dci;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [RW-1:0] q[$];
  int fifo_cnt = 0, pend_cnt = 0;
  logic [ICW-1:0] seq = '0;

  always #2 clk = ~clk;

  replay_io_logger #(.ICW(ICW), .DW(DW), .TW(TW), .DEPTH(DEPTH)) i_replay_io_logger (
    .clk(clk), .rst(rst), .icount(icount),
    .trap_valid(trap_valid), .trap_async(trap_async), .trap_type(trap_type),
    .io_valid(io_valid), .io_is_load(io_is_load), .io_data(io_data),
    .dma_valid(dma_valid), .dma_data(dma_data),
    .dma_conflict(dma_conflict), .dma_conflict_ic(dma_conflict_ic),
    .stall(stall), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_kind(rec_kind), .rec_count(rec_count), .rec_data(rec_data));

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] mkrec(input logic [1:0] k, input logic [ICW-1:0] c, input logic [DW-1:0] d);
    return {k, c, d};
  endfunction

  function automatic string kind_tag(input logic [1:0] k);
    case (k)
      2'd0: return "R2 R8 R10";
      2'd1: return "R4 R8 R10";
      2'd2: return "R6 R8 R10";
      default: return "R7 R8 R10";
    endcase
  endfunction

  function automatic bit exp_stall();
    return (pend_cnt > 0) || (fifo_cnt == DEPTH);
  endfunction

  task automatic idle_stage();
    n_tv = 0; n_ta = 0; n_iv = 0; n_il = 0; n_dv = 0; n_dc = 0;
    n_tt = '0; n_id = '0; n_dd = '0; n_dci = '0; n_ic = icount + 1'b1;
  endtask

  task automatic apply();
    bit acc, pop;
    int n, w;
    @(negedge clk);
    check(stall == exp_stall(), "R9 stall", RW'(stall), RW'(exp_stall()));
    check(rec_valid == (fifo_cnt > 0), "R10 valid", RW'(rec_valid), RW'(fifo_cnt > 0));
    if (fifo_cnt > 0)
      check({rec_kind, rec_count, rec_data} == q[0], kind_tag(q[0][RW-1 -: 2]),
            {rec_kind, rec_count, rec_data}, q[0]);
    trap_valid = n_tv; trap_async = n_ta; trap_type = n_tt;
    io_valid = n_iv; io_is_load = n_il; io_data = n_id;
    dma_valid = n_dv; dma_conflict = n_dc; dma_data = n_dd; dma_conflict_ic = n_dci;
    icount = n_ic; rec_ready = n_rdy;
    acc = !exp_stall();
    pop = rec_ready && (fifo_cnt > 0);
    if (pop) void'(q.pop_front());
    w = 0;
    if (acc) begin
      n = 0;
      if (n_tv && n_ta) begin q.push_back(mkrec(2'd0, n_ic, DW'(n_tt))); n++; end
      if (n_iv && n_il) begin q.push_back(mkrec(2'd1, n_ic, n_id)); n++; end
      if (n_dv) begin
        seq = seq + 1'b1;
        q.push_back(mkrec(2'd2, seq, n_dd)); n++;
        if (n_dc) begin q.push_back(mkrec(2'd3, seq, DW'(n_dci))); n++; end
      end
      if (n > 0) begin w = 1; pend_cnt = n - 1; end
    end else if (pend_cnt > 0 && fifo_cnt < DEPTH) begin
      w = 1; pend_cnt--;
    end
    fifo_cnt = fifo_cnt + w - int'(pop);
  endtask

  task automatic rand_stage(input int ready_pct);
    idle_stage();
    n_tv = ($urandom % 6) == 0; n_ta = $urandom % 2; n_tt = TW'($urandom);
    n_iv = ($urandom % 5) == 0; n_il = $urandom % 2; n_id = $urandom;
    n_dv = ($urandom % 4) == 0; n_dc = ($urandom % 3) == 0;
    n_dd = $urandom; n_dci = ICW'($urandom);
    n_ic = icount + ICW'($urandom % 3);
    n_rdy = ($urandom % 100) < ready_pct;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    n_rdy = 1;
    idle_stage();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(stall == 0, "R1 stall", RW'(stall), '0);
    check(rec_valid == 0, "R1 valid", RW'(rec_valid), '0);

    // R2: single interrupt
    idle_stage(); n_tv = 1; n_ta = 1; n_tt = 4'h5; n_rdy = 1; apply();
    idle_stage(); apply(); apply(); apply();

    // R3: synchronous exception alone leaves no record
    idle_stage(); n_tv = 1; n_ta = 0; n_tt = 4'h9; apply();
    idle_stage(); apply();
    check(rec_valid == 0, "R3 exception logged", RW'(rec_valid), '0);

    // R5: I/O store alone leaves no record
    idle_stage(); n_iv = 1; n_il = 0; n_id = 32'hDEAD_BEEF; apply();
    idle_stage(); apply();
    check(rec_valid == 0, "R5 store logged", RW'(rec_valid), '0);

    // R4, R6, R7: I/O load, then a conflicting DMA beat (first beat count 1)
    idle_stage(); n_iv = 1; n_il = 1; n_id = 32'h1234_5678; apply();
    idle_stage(); n_dv = 1; n_dc = 1; n_dd = 32'hCAFE_0001; n_dci = 16'h0042; apply();
    idle_stage(); repeat (4) apply();

    // R8: all four record kinds in one cycle
    idle_stage(); n_tv = 1; n_ta = 1; n_tt = 4'hA; n_iv = 1; n_il = 1; n_id = 32'h0BAD_F00D;
    n_dv = 1; n_dc = 1; n_dd = 32'h5555_AAAA; n_dci = 16'h7777; apply();
    idle_stage(); repeat (8) apply();

    // R9: fill the FIFO with the consumer held off, keep offering events
    for (int i = 0; i < 40; i++) begin rand_stage(0); n_tv = 1; n_ta = 1; apply(); end
    for (int i = 0; i < 30; i++) begin rand_stage(100); apply(); end

    // random mix
    for (int i = 0; i < 4000; i++) begin rand_stage((i / 500) % 2 ? 30 : 85); apply(); end
    idle_stage(); n_rdy = 1;
    repeat (20) apply();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule